// File: doc/BRIEF.md
# Fractional PLL Ratio Calculator

This block turns a feedback multiplier N and a reference divider M into the four internal settings that a fractional feedback divider needs. It picks a pre-scale exponent P from the integer base-2 log of N/M, with P clamped at zero. It forms the scaled numerator N' = N·2^P. It then splits N' into an integer quotient Q and a remainder R with respect to M. Each result is checked against the legal limits. A valid flag and a two-bit reason code tell whether the setting can be used.

The unit runs over several cycles. A one-cycle start request latches the operands. The log is found by shifting M left one place per cycle, and Q and R come from a restoring divider that produces one quotient bit per cycle. When the results are ready, a one-cycle done pulse marks them. As an option, the block also sorts a supplied VCO frequency in MHz into one of four band codes and publishes that code with the results.

Top module: `pll_ratio_calc`

## Requirements
- R1: After reset, and until the first result, busy_o, done_o and valid_o are low, and err_o, band_o, p_o, nsc_o, q_o and r_o are all zero.
- R2: For legal operands, p_o = 4 − k, where k is the largest integer with M·2^k ≤ N. When k exceeds 4, p_o is 0.
- R3: nsc_o equals N shifted left by p_o places.
- R4: q_o = floor(nsc_o / M) and r_o = nsc_o − M·q_o, so r_o < M.
- R5: If N or M is zero, err_o is 2'b01. In that case p_o, nsc_o, q_o and r_o are zero, and done_o pulses in the cycle after the start.
- R6: If both operands are non-zero and N < M, err_o is 2'b10, and p_o, nsc_o, q_o and r_o are zero.
- R7: If the computed Q lies outside 16..63, err_o is 2'b11 and the computed fields are still reported. valid_o is high exactly when err_o is 2'b00.
- R8: done_o is high for exactly one cycle per accepted start. busy_o is high while a legal operand pair is being computed. A start_i raised while busy_o is high is ignored.
- R9: All result outputs hold their values from the done pulse until the next accepted start.
- R10: band_o is taken from vco_mhz_i at the accepted start and published with the results: 2'b00 below 125, 2'b01 for 125 to 149, 2'b10 for 150 to 174, and 2'b11 at 175 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| n_i | input | 12 | Feedback multiplier N |
| m_i | input | 9 | Reference divider M |
| vco_mhz_i | input | 8 | VCO frequency in MHz for the band code |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result strobe |
| valid_o | output | 1 | Result within all limits |
| err_o | output | 2 | Reason code: 00 none, 01 zero operand, 10 N below M, 11 Q out of range |
| band_o | output | 2 | VCO band code |
| p_o | output | 3 | Pre-scale exponent P |
| nsc_o | output | 16 | Scaled numerator N' |
| q_o | output | 16 | Integer quotient Q |
| r_o | output | 9 | Remainder R |

## Verification
The assertions in the log stage and the divider assume that those stages are launched only with a non-zero M that does not exceed N. They also assume the divisor stays fixed for the whole division. The top module enforces both conditions by screening the operands before it starts either stage, and the bench still drives zero, reversed and extreme operands to exercise that screening. The bench raises start_i only while the block is idle, with one deliberate exception: an extra start during a computation, used to check that such a request is ignored. It holds the operands steady for the whole start cycle.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_ZERO   = 2'b01,
    ERR_ORDER  = 2'b10,
    ERR_QRANGE = 2'b11
  } calc_err_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LOG  = 2'b01,
    ST_DIV  = 2'b10
  } calc_state_e;
endpackage

// File: rtl/ratio_log2.sv
module ratio_log2 #(
  parameter int N_W = 12,
  parameter int M_W = 9,
  parameter int K_W = $clog2(N_W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [N_W-1:0] n_i,
  input  logic [M_W-1:0] m_i,
  output logic           done_o,
  output logic [K_W-1:0] k_o
);
  logic           busy_q;
  logic [N_W-1:0] n_q, sh_q;
  logic [N_W:0]   sh_next;

  assign sh_next = {sh_q, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_o <= 1'b0;
      n_q    <= '0;
      sh_q   <= '0;
      k_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        n_q    <= n_i;
        sh_q   <= N_W'(m_i);
        k_o    <= '0;
      end else if (busy_q) begin
        if (sh_next <= {1'b0, n_q}) begin
          sh_q <= sh_next[N_W-1:0];
          k_o  <= k_o + 1'b1;
        end else begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // precondition screened by the parent
  assert_log_pre_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (m_i != '0) && (N_W'(m_i) <= n_i));
  assert_shift_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (sh_q <= n_q) && (sh_q != '0));
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
  parameter int DW = 16,
  parameter int VW = 9,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quo_o,
  output logic [VW-1:0] rem_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [VW-1:0] dv_q;
  logic [VW:0]   shift_w, diff_w;
  logic          ge_w;

  always_comb begin
    shift_w = {rem_o, quo_o[DW-1]};
    ge_w    = shift_w >= {1'b0, dv_q};
    diff_w  = shift_w - {1'b0, dv_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
      dv_q   <= '0;
      quo_o  <= '0;
      rem_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(DW);
        dv_q   <= divisor_i;
        quo_o  <= dividend_i;
        rem_o  <= '0;
      end else if (busy_q) begin
        rem_o <= ge_w ? diff_w[VW-1:0] : shift_w[VW-1:0];
        quo_o <= {quo_o[DW-2:0], ge_w};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assert_div_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> divisor_i != '0);
  assert_rem_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_o < dv_q);
endmodule

// File: rtl/vco_band_sel.sv
module vco_band_sel #(
  parameter int F_W     = 8,
  parameter bit EN_BAND = 1'b1,
  parameter int EDGE_1  = 125,
  parameter int EDGE_2  = 150,
  parameter int EDGE_3  = 175
) (
  input  logic [F_W-1:0] mhz_i,
  output logic [1:0]     band_o
);
  if (EN_BAND) begin : g_band
    always_comb begin
      if      (32'(mhz_i) < EDGE_1) band_o = 2'b00;
      else if (32'(mhz_i) < EDGE_2) band_o = 2'b01;
      else if (32'(mhz_i) < EDGE_3) band_o = 2'b10;
      else                          band_o = 2'b11;
    end
  end else begin : g_noband
    assign band_o = 2'b00;
  end
endmodule

// File: rtl/pll_ratio_calc.sv
module pll_ratio_calc
  import pll_calc_pkg::*;
#(
  parameter int N_W     = 12,
  parameter int M_W     = 9,
  parameter int F_W     = 8,
  parameter int P_TOP   = 4,
  parameter int Q_LO    = 16,
  parameter int Q_HI    = 63,
  parameter bit EN_BAND = 1'b1,
  localparam int P_W  = $clog2(P_TOP + 1),
  localparam int NS_W = N_W + P_TOP,
  localparam int K_W  = $clog2(N_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N_W-1:0]  n_i,
  input  logic [M_W-1:0]  m_i,
  input  logic [F_W-1:0]  vco_mhz_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            valid_o,
  output logic [1:0]      err_o,
  output logic [1:0]      band_o,
  output logic [P_W-1:0]  p_o,
  output logic [NS_W-1:0] nsc_o,
  output logic [NS_W-1:0] q_o,
  output logic [M_W-1:0]  r_o
);
  calc_state_e    state_q;
  logic [N_W-1:0] n_q;
  logic [M_W-1:0] m_q;
  logic [P_W-1:0] p_q;
  logic [1:0]     band_pend_q, band_w;
  logic           accept_w, zero_w, order_w, log_go_w, div_go_w;
  logic           log_done_w, div_done_w;
  logic [K_W-1:0] k_w;
  logic [P_W-1:0] p_w;
  logic [NS_W-1:0] quo_w;
  logic [M_W-1:0]  rem_w;
  logic           qbad_w;

  assign accept_w = (state_q == ST_IDLE) && start_i;
  assign zero_w   = (n_i == '0) || (m_i == '0);
  assign order_w  = n_i < N_W'(m_i);
  assign log_go_w = accept_w && !zero_w && !order_w;
  assign p_w      = (k_w > K_W'(P_TOP)) ? '0 : P_W'(P_TOP - int'(k_w));
  assign div_go_w = (state_q == ST_LOG) && log_done_w;
  assign qbad_w   = (quo_w < NS_W'(Q_LO)) || (quo_w > NS_W'(Q_HI));
  assign busy_o   = state_q != ST_IDLE;

  vco_band_sel #(.F_W(F_W), .EN_BAND(EN_BAND)) u_band (
    .mhz_i (vco_mhz_i),
    .band_o(band_w)
  );

  ratio_log2 #(.N_W(N_W), .M_W(M_W), .K_W(K_W)) u_log (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (log_go_w),
    .n_i   (n_i),
    .m_i   (m_i),
    .done_o(log_done_w),
    .k_o   (k_w)
  );

  restoring_div #(.DW(NS_W), .VW(M_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (div_go_w),
    .dividend_i(NS_W'(n_q) << p_w),
    .divisor_i (m_q),
    .done_o    (div_done_w),
    .quo_o     (quo_w),
    .rem_o     (rem_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      n_q         <= '0;
      m_q         <= '0;
      p_q         <= '0;
      band_pend_q <= '0;
      done_o      <= 1'b0;
      valid_o     <= 1'b0;
      err_o       <= ERR_NONE;
      band_o      <= '0;
      p_o         <= '0;
      nsc_o       <= '0;
      q_o         <= '0;
      r_o         <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          n_q         <= n_i;
          m_q         <= m_i;
          band_pend_q <= band_w;
          if (zero_w || order_w) begin
            done_o  <= 1'b1;
            valid_o <= 1'b0;
            err_o   <= zero_w ? ERR_ZERO : ERR_ORDER;
            band_o  <= band_w;
            p_o     <= '0;
            nsc_o   <= '0;
            q_o     <= '0;
            r_o     <= '0;
          end else begin
            state_q <= ST_LOG;
          end
        end
        ST_LOG: if (log_done_w) begin
          p_q     <= p_w;
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_done_w) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          valid_o <= !qbad_w;
          err_o   <= qbad_w ? ERR_QRANGE : ERR_NONE;
          band_o  <= band_pend_q;
          p_o     <= p_q;
          nsc_o   <= NS_W'(n_q) << p_q;
          q_o     <= quo_w;
          r_o     <= rem_w;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(q_o) && $stable(r_o) && $stable(err_o) && $stable(p_o));
  assert_p_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> p_o <= P_W'(P_TOP));
  assert_q_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> (q_o >= NS_W'(Q_LO)) && (q_o <= NS_W'(Q_HI)) && (r_o < m_q));
endmodule

// File: tb/sim_pll_ratio_calc.sv
module sim_pll_ratio_calc;
  typedef struct packed {
    logic [1:0]  err;
    logic        valid;
    logic [1:0]  band;
    logic [2:0]  p;
    logic [15:0] nsc;
    logic [15:0] q;
    logic [8:0]  r;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] n = '0;
  logic [8:0]  m = '0;
  logic [7:0]  vco = '0;
  logic        busy, done, valid;
  logic [1:0]  err, band;
  logic [2:0]  p;
  logic [15:0] nsc, q;
  logic [8:0]  r;

  int   checks = 0;
  int   fails = 0;
  bit   mon_busy = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  pll_ratio_calc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_i(n), .m_i(m),
    .vco_mhz_i(vco), .busy_o(busy), .done_o(done), .valid_o(valid),
    .err_o(err), .band_o(band), .p_o(p), .nsc_o(nsc), .q_o(q), .r_o(r)
  );

  function automatic exp_t model(int nn, int mm, int vv);
    exp_t e;
    int k, pp, ns;
    e = '0;
    e.band = (vv < 125) ? 2'd0 : (vv < 150) ? 2'd1 : (vv < 175) ? 2'd2 : 2'd3;
    if (nn == 0 || mm == 0) e.err = 2'b01;
    else if (nn < mm) e.err = 2'b10;
    else begin
      k = 0;
      while ((mm << (k + 1)) <= nn) k++;
      pp = (k > 4) ? 0 : 4 - k;
      ns = nn << pp;
      e.p = 3'(pp);
      e.nsc = 16'(ns);
      e.q = 16'(ns / mm);
      e.r = 9'(ns % mm);
      e.err = (ns / mm < 16 || ns / mm > 63) ? 2'b11 : 2'b00;
    end
    e.valid = (e.err == 2'b00);
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t observed();
    exp_t o;
    o.err = err; o.valid = valid; o.band = band; o.p = p;
    o.nsc = nsc; o.q = q; o.r = r;
    return o;
  endfunction

  task automatic compare(exp_t a, exp_t e, string tag);
    chk(a.err == e.err, e.err == 2'b01 ? "R5" : e.err == 2'b10 ? "R6" : "R7", {tag, " err"}, a.err, e.err);
    chk(a.valid == e.valid, "R7", {tag, " valid"}, a.valid, e.valid);
    chk(a.band == e.band, "R10", {tag, " band"}, a.band, e.band);
    chk(a.p == e.p, "R2", {tag, " p"}, a.p, e.p);
    chk(a.nsc == e.nsc, "R3", {tag, " nsc"}, a.nsc, e.nsc);
    chk(a.q == e.q, "R4", {tag, " q"}, a.q, e.q);
    chk(a.r == e.r, "R4", {tag, " r"}, a.r, e.r);
  endtask

  // monitor: pop on each done, check pulse width and hold
  initial begin
    exp_t e, a;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        mon_busy = 1'b1;
        if (sb.size() == 0) chk(1'b0, "R8", "unexpected done", 1, 0);
        else begin
          e = sb.pop_front();
          a = observed();
          compare(a, e, "result");
          @(negedge clk);
          chk(done == 1'b0, "R8", "done width", done, 0);
          repeat (3) @(negedge clk);
          compare(observed(), e, "hold R9");
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic run_op(int nn, int mm, int vv, bit poke);
    sb.push_back(model(nn, mm, vv));
    @(negedge clk);
    start = 1'b1; n = 12'(nn); m = 9'(mm); vco = 8'(vv);
    @(negedge clk);
    start = 1'b0;
    if (nn != 0 && mm != 0 && nn >= mm)
      chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; n = 12'd5; m = 9'd3; vco = 8'd10;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (sb.size() != 0 || mon_busy);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !valid, "R1", "flags at reset", {busy, done, valid}, 0);
    chk(err == 0 && band == 0 && p == 0, "R1", "codes at reset", {err, band, p}, 0);
    chk(nsc == 0 && q == 0 && r == 0, "R1", "fields at reset", q, 0);

    run_op(4, 1, 100, 0);     // R2 P=2 N'=16 Q=16
    run_op(11, 2, 148, 0);    // R3 N'=44 Q=22, band 01
    run_op(7, 7, 150, 0);     // equal operands, P=4
    run_op(9, 5, 174, 0);     // R4 remainder 4
    run_op(4095, 511, 175, 0);
    run_op(100, 3, 200, 0);   // k=5 clamp, Q=33
    run_op(200, 2, 124, 0);   // R7 Q=100
    run_op(4095, 1, 255, 0);  // R7 extreme
    run_op(0, 5, 0, 0);       // R5
    run_op(8, 0, 130, 0);     // R5
    run_op(3, 7, 160, 0);     // R6
    run_op(1, 511, 90, 0);    // R6
    run_op(37, 4, 140, 1);    // R8 start while busy ignored
    run_op(600, 9, 180, 1);   // R8

    seed = 7;
    for (int i = 0; i < 40; i++) begin
      int nn, mm, vv;
      seed = seed * 1103515245 + 12345;
      nn = (seed >>> 8) & 12'hFFF;
      seed = seed * 1103515245 + 12345;
      mm = ((seed >>> 8) & 9'h1FF) | 1;
      seed = seed * 1103515245 + 12345;
      vv = (seed >>> 8) & 8'hFF;
      run_op(nn, mm, vv, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule